// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is one channel of a direct-memory-access engine. A start pulse latches a configuration. The configuration names the endpoint class of each side, single or dual addressing, direct or pointer-indirect source addressing, cycle-steal or burst bus holding, a unit size and a unit count. The sequencer first tests that configuration against a fixed legality matrix. An illegal setup ends with a one-cycle error pulse and no bus activity.

A legal setup is carried out over a request/grant bus-master port with read and write strobes. Accesses toward a handshake device are marked by an acknowledge strobe. When the last unit has moved, a one-cycle completion pulse follows. Bus accesses complete in the cycle their strobe is high while grant is held, and read data is taken in that same cycle.

Endpoint class encoding on `cfg_src_ep`/`cfg_dst_ep`: 0 = handshake device, 1 = external memory, 2 = memory-mapped external device, 3 = on-chip peripheral. Unit size encoding on `cfg_size`: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 16 bytes.

Top module: `dma_seq_top`

## Requirements
- R1: A configuration is refused if the handshake device (class 0) is paired with class 0 or class 3, or if the count is zero. A refused configuration gives a one-cycle `cfg_err` pulse, no `done`, and `bus_req` never rises.
- R2: Single addressing (`cfg_dual`=0) is legal only when exactly one side is class 0 and the other side is class 1 or 2. Any other single-addressing setup is refused as in R1.
- R3: A 16-byte unit (`cfg_size`=3) with either side of class 3 is refused as in R1.
- R4: In dual direct mode, each unit is a read at the source address followed by a write at the destination address. The write carries the data returned by the read.
- R5: With `cfg_indirect`=1 in dual mode, each unit starts with a pointer read at the source address, and the data reads use the returned word as their address. In single mode the flag has no effect.
- R6: In single mode, each beat is one bus cycle at the memory-side address with `dack` high. It is a read when the destination is class 0 and a write otherwise, never both.
- R7: After each unit, both addresses advance by the unit size in bytes (1, 2, 4 or 16). `done` pulses for exactly one clock after the last unit.
- R8: In cycle-steal mode `bus_req` drops for at least one clock between units, so it rises once per unit. In burst mode it rises once per transfer.
- R9: A 16-byte unit moves as four 32-bit beats at offsets 0, 4, 8 and 12. All four reads come before the four writes in dual mode.
- R10: Strobes are high only while `bus_gnt` is high. A withheld grant stalls the sequence with `bus_addr` held.
- R11: A start pulse while a transfer runs is ignored. A start in the cycle `done` is high is accepted.
- R12: After reset, `bus_req`, `bus_rd`, `bus_wr`, `dack`, `done` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled when idle |
| cfg_src_ep | input | 2 | Source endpoint class |
| cfg_dst_ep | input | 2 | Destination endpoint class |
| cfg_dual | input | 1 | 1 = dual addressing, 0 = single |
| cfg_indirect | input | 1 | 1 = source pointer-indirect |
| cfg_burst | input | 1 | 1 = burst, 0 = cycle steal |
| cfg_size | input | 2 | Unit size code |
| cfg_count | input | CW | Number of units |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Access address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdata | input | DW | Read data, valid with `bus_rd` |
| bus_wdata | output | DW | Write data |
| dack | output | 1 | Handshake acknowledge strobe |
| done | output | 1 | Transfer complete pulse |
| cfg_err | output | 1 | Configuration refused pulse |

## Verification
The completion pulse of one transfer and the acceptance of the next start can fall in the same cycle. The bench watches for `done` at the falling edge and, in that same half cycle, drives a new configuration and raises `start`. The pulse is therefore sampled at the edge where `done` is still high. The second transfer is judged accepted only if its full stream of bus events matches the scoreboard and its own `done` arrives with no `cfg_err`.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    EP_HSDEV  = 2'd0,
    EP_XMEM   = 2'd1,
    EP_MMIO   = 2'd2,
    EP_ONCHIP = 2'd3
  } ep_e;

  typedef enum logic [1:0] {
    SZ_1  = 2'd0,
    SZ_2  = 2'd1,
    SZ_4  = 2'd2,
    SZ_16 = 2'd3
  } usz_e;

  typedef enum logic [2:0] {
    PH_NONE,
    PH_PTR,
    PH_RD,
    PH_WR,
    PH_SGL
  } phase_e;

  typedef struct packed {
    ep_e  src;
    ep_e  dst;
    logic dual;
    logic indirect;
    logic burst;
    usz_e size;
  } cfg_t;

endpackage

// File: rtl/dma_seq_legal.sv
module dma_seq_legal
  import dma_seq_pkg::*;
(
  input  cfg_t cfg,
  input  logic count_zero,
  output logic legal_ok
);

  logic hs_src, hs_dst;
  ep_e  far_side;
  logic bad_pair, bad_mode, bad_size, single_ok;

  always_comb begin
    hs_src    = (cfg.src == EP_HSDEV);
    hs_dst    = (cfg.dst == EP_HSDEV);
    far_side  = hs_src ? cfg.dst : cfg.src;
    bad_pair  = (hs_src || hs_dst) &&
                (far_side == EP_HSDEV || far_side == EP_ONCHIP);
    single_ok = (hs_src ^ hs_dst) &&
                (far_side == EP_XMEM || far_side == EP_MMIO);
    bad_mode  = !cfg.dual && !single_ok;
    bad_size  = (cfg.size == SZ_16) &&
                (cfg.src == EP_ONCHIP || cfg.dst == EP_ONCHIP);
    legal_ok  = !(bad_pair || bad_mode || bad_size || count_zero);
  end

endmodule

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  cfg_t          cfg_in,
  input  logic [CW-1:0] cnt_in,
  input  logic [AW-1:0] saddr_in,
  input  logic [AW-1:0] daddr_in,
  input  phase_e        phase,
  input  logic          beat_inc,
  input  logic          beat_clr,
  input  logic          ptr_ld,
  input  logic          buf_wr,
  input  logic          unit_adv,
  input  logic [DW-1:0] rdata,
  output cfg_t          cfg_q,
  output logic          count_zero,
  output logic          count_last,
  output logic          beat_last,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);

  localparam int WB    = DW / 8;
  localparam int BEATS = 16 / WB;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  cfg_t          cfg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] src_q, src_d, dst_q, dst_d, ptr_q, ptr_d;
  logic [BW-1:0] beat_q, beat_d;
  logic [AW-1:0] unit_bytes, beat_off, rd_base, sgl_base;
  logic [DW-1:0] buf_rd [BEATS];

  // unit size in bytes and the offset of the current beat
  always_comb begin
    case (cfg_q.size)
      SZ_1:    unit_bytes = AW'(1);
      SZ_2:    unit_bytes = AW'(2);
      SZ_4:    unit_bytes = AW'(4);
      default: unit_bytes = AW'(16);
    endcase
    beat_off   = (cfg_q.size == SZ_16) ? AW'(beat_q) * AW'(WB) : '0;
    beat_last  = (cfg_q.size == SZ_16) ? (beat_q == BW'(BEATS - 1)) : 1'b1;
    count_zero = (cnt_q == '0);
    count_last = (cnt_q == CW'(1));
  end

  // next-state of the configuration, counters and address registers
  always_comb begin
    cfg_d  = cfg_q;
    cnt_d  = cnt_q;
    src_d  = src_q;
    dst_d  = dst_q;
    ptr_d  = ptr_q;
    beat_d = beat_q;
    if (ld) begin
      cfg_d  = cfg_in;
      cnt_d  = cnt_in;
      src_d  = saddr_in;
      dst_d  = daddr_in;
      beat_d = '0;
    end else begin
      if (unit_adv) begin
        cnt_d = cnt_q - CW'(1);
        src_d = src_q + unit_bytes;
        dst_d = dst_q + unit_bytes;
      end
      if (ptr_ld) ptr_d = AW'(rdata);
      if (beat_clr)      beat_d = '0;
      else if (beat_inc) beat_d = beat_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      ptr_q  <= '0;
      beat_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      cnt_q  <= cnt_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      ptr_q  <= ptr_d;
      beat_q <= beat_d;
    end
  end

  // one data word of buffer per beat
  for (genvar g = 0; g < BEATS; g++) begin : g_buf
    logic [DW-1:0] word_q, word_d;
    logic          word_en;
    always_comb begin
      word_en = buf_wr && (beat_q == BW'(g));
      word_d  = word_en ? rdata : word_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end
    assign buf_rd[g] = word_q;
  end

  // access address and write data for the current phase
  always_comb begin
    rd_base  = cfg_q.indirect ? ptr_q : src_q;
    sgl_base = (cfg_q.dst == EP_HSDEV) ? src_q : dst_q;
    case (phase)
      PH_PTR:  addr = src_q;
      PH_RD:   addr = rd_base + beat_off;
      PH_WR:   addr = dst_q + beat_off;
      PH_SGL:  addr = sgl_base + beat_off;
      default: addr = '0;
    endcase
    wdata = (phase == PH_WR) ? buf_rd[beat_q] : '0;
  end

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   mode_dual,
  input  logic   mode_indirect,
  input  logic   mode_burst,
  input  logic   mem_is_src,
  input  logic   legal_ok,
  input  logic   beat_last,
  input  logic   count_last,
  input  logic   bus_gnt,
  output logic   ld,
  output phase_e phase,
  output logic   beat_inc,
  output logic   beat_clr,
  output logic   ptr_ld,
  output logic   buf_wr,
  output logic   unit_adv,
  output logic   bus_req,
  output logic   bus_rd,
  output logic   bus_wr,
  output logic   dack,
  output logic   done,
  output logic   cfg_err
);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_REQ, S_PTR, S_RD, S_WR, S_SGL, S_GAP
  } st_e;

  st_e  st_q, st_d, first_st;
  logic done_d, err_d, unit_end;

  always_comb begin
    first_st = !mode_dual ? S_SGL : (mode_indirect ? S_PTR : S_RD);
  end

  // next-state logic
  always_comb begin
    st_d     = st_q;
    ld       = 1'b0;
    beat_inc = 1'b0;
    beat_clr = 1'b0;
    ptr_ld   = 1'b0;
    buf_wr   = 1'b0;
    unit_end = 1'b0;
    done_d   = 1'b0;
    err_d    = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        ld   = 1'b1;
        st_d = S_CHECK;
      end
      S_CHECK: begin
        if (legal_ok) st_d = S_REQ;
        else begin
          err_d = 1'b1;
          st_d  = S_IDLE;
        end
      end
      S_REQ: if (bus_gnt) st_d = first_st;
      S_PTR: if (bus_gnt) begin
        ptr_ld = 1'b1;
        st_d   = S_RD;
      end
      S_RD: if (bus_gnt) begin
        buf_wr = 1'b1;
        if (beat_last) begin
          beat_clr = 1'b1;
          st_d     = S_WR;
        end else beat_inc = 1'b1;
      end
      S_WR, S_SGL: if (bus_gnt) begin
        if (beat_last) begin
          beat_clr = 1'b1;
          unit_end = 1'b1;
        end else beat_inc = 1'b1;
      end
      S_GAP:   st_d = S_REQ;
      default: st_d = S_IDLE;
    endcase
    if (unit_end) begin
      if (count_last) begin
        done_d = 1'b1;
        st_d   = S_IDLE;
      end else if (mode_burst) st_d = first_st;
      else                     st_d = S_GAP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      done    <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      st_q    <= st_d;
      done    <= done_d;
      cfg_err <= err_d;
    end
  end

  // outputs decoded from the current state
  always_comb begin
    unit_adv = unit_end;
    bus_req  = (st_q == S_REQ) || (st_q == S_PTR) || (st_q == S_RD) ||
               (st_q == S_WR) || (st_q == S_SGL);
    case (st_q)
      S_PTR:   phase = PH_PTR;
      S_RD:    phase = PH_RD;
      S_WR:    phase = PH_WR;
      S_SGL:   phase = PH_SGL;
      default: phase = PH_NONE;
    endcase
    bus_rd = bus_gnt && ((st_q == S_PTR) || (st_q == S_RD) ||
                         ((st_q == S_SGL) && mem_is_src));
    bus_wr = bus_gnt && ((st_q == S_WR) || ((st_q == S_SGL) && !mem_is_src));
    dack   = bus_gnt && (st_q == S_SGL);
  end

  assert_done_onecycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_cfgerr_onecycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !cfg_err);

  assert_strobe_needs_gnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr || dack) |-> (bus_gnt && bus_req));

  assert_rd_wr_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    cfg_src_ep,
  input  logic [1:0]    cfg_dst_ep,
  input  logic          cfg_dual,
  input  logic          cfg_indirect,
  input  logic          cfg_burst,
  input  logic [1:0]    cfg_size,
  input  logic [CW-1:0] cfg_count,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] bus_wdata,
  output logic          dack,
  output logic          done,
  output logic          cfg_err
);

  cfg_t   cfg_in, cfg_q;
  phase_e phase;
  logic   ld, beat_inc, beat_clr, ptr_ld, buf_wr, unit_adv;
  logic   count_zero, count_last, beat_last, legal_ok;

  always_comb begin
    cfg_in.src      = ep_e'(cfg_src_ep);
    cfg_in.dst      = ep_e'(cfg_dst_ep);
    cfg_in.dual     = cfg_dual;
    cfg_in.indirect = cfg_indirect;
    cfg_in.burst    = cfg_burst;
    cfg_in.size     = usz_e'(cfg_size);
  end

  dma_seq_legal u_legal (
    .cfg        (cfg_q),
    .count_zero (count_zero),
    .legal_ok   (legal_ok)
  );

  dma_seq_datapath #(.AW(AW), .DW(DW), .CW(CW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld         (ld),
    .cfg_in     (cfg_in),
    .cnt_in     (cfg_count),
    .saddr_in   (cfg_src_addr),
    .daddr_in   (cfg_dst_addr),
    .phase      (phase),
    .beat_inc   (beat_inc),
    .beat_clr   (beat_clr),
    .ptr_ld     (ptr_ld),
    .buf_wr     (buf_wr),
    .unit_adv   (unit_adv),
    .rdata      (bus_rdata),
    .cfg_q      (cfg_q),
    .count_zero (count_zero),
    .count_last (count_last),
    .beat_last  (beat_last),
    .addr       (bus_addr),
    .wdata      (bus_wdata)
  );

  dma_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .mode_dual     (cfg_q.dual),
    .mode_indirect (cfg_q.indirect),
    .mode_burst    (cfg_q.burst),
    .mem_is_src    (cfg_q.dst == EP_HSDEV),
    .legal_ok      (legal_ok),
    .beat_last     (beat_last),
    .count_last    (count_last),
    .bus_gnt       (bus_gnt),
    .ld            (ld),
    .phase         (phase),
    .beat_inc      (beat_inc),
    .beat_clr      (beat_clr),
    .ptr_ld        (ptr_ld),
    .buf_wr        (buf_wr),
    .unit_adv      (unit_adv),
    .bus_req       (bus_req),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .dack          (dack),
    .done          (done),
    .cfg_err       (cfg_err)
  );

  assert_addr_held_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> $stable(bus_addr));

  assert_dack_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (bus_rd ^ bus_wr));

endmodule

// File: tb/dma_seq_top_tb.sv
module dma_seq_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cfg_src_ep = '0, cfg_dst_ep = '0, cfg_size = '0;
  logic        cfg_dual = 1'b0, cfg_indirect = 1'b0, cfg_burst = 1'b0;
  logic [15:0] cfg_count = '0;
  logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic        bus_req, bus_gnt, bus_rd, bus_wr, dack, done, cfg_err;
  logic [31:0] bus_addr, bus_rdata, bus_wdata;
  logic        gnt_block = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [31:0] memval(input logic [31:0] a);
    return 32'h1000_0000 | ({26'd0, a[7:2]} * 32'h0001_0044);
  endfunction

  assign bus_gnt   = bus_req && !gnt_block;
  assign bus_rdata = memval(bus_addr);

  dma_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_ep(cfg_src_ep), .cfg_dst_ep(cfg_dst_ep), .cfg_dual(cfg_dual),
    .cfg_indirect(cfg_indirect), .cfg_burst(cfg_burst), .cfg_size(cfg_size),
    .cfg_count(cfg_count), .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_wdata(bus_wdata),
    .dack(dack), .done(done), .cfg_err(cfg_err)
  );

  typedef struct {
    logic        rd, wr, dk, chk_data;
    logic [31:0] addr, data;
  } ev_t;

  ev_t   exp_q[$];
  int    total = 0, failed = 0;
  int    rises = 0, strobes = 0, blocked = 0, errs = 0;
  logic  req_prev = 1'b0;
  string cur_tag = "R12";
  bit    finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected bus events and compares
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req && !req_prev) rises++;
      req_prev = bus_req;
      if (cfg_err) errs++;
      if (bus_rd || bus_wr || dack) begin
        strobes++;
        if (gnt_block) blocked++;
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected bus event addr", bus_addr, 0);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk({bus_rd, bus_wr, dack} == {e.rd, e.wr, e.dk}, cur_tag,
              "strobes rd/wr/dack", {bus_rd, bus_wr, dack}, {e.rd, e.wr, e.dk});
          chk(bus_addr == e.addr, cur_tag, "address", bus_addr, e.addr);
          if (e.chk_data)
            chk(bus_wdata == e.data, cur_tag, "write data", bus_wdata, e.data);
        end
      end
    end
  end

  task automatic push(input logic rd, wr, dk, input logic [31:0] a,
                      input logic cd, input logic [31:0] d);
    ev_t e;
    e.rd = rd; e.wr = wr; e.dk = dk; e.addr = a; e.chk_data = cd; e.data = d;
    exp_q.push_back(e);
  endtask

  // driver: builds the expected stream from the requirements, then runs
  task automatic run_job(input string tag, input logic [1:0] se, de,
                         input logic du, ind, bu, input logic [1:0] sz,
                         input int cnt, input logic [31:0] sa, da,
                         input bit exp_ok);
    int          bytes, beats;
    bit          got_done, got_err;
    logic [31:0] s, d, base, m;
    bytes = (sz == 2'd3) ? 16 : (1 << sz);
    beats = (sz == 2'd3) ? 4 : 1;
    if (exp_ok) begin
      for (int u = 0; u < cnt; u++) begin
        s = sa + u * bytes;
        d = da + u * bytes;
        if (!du) begin
          m = (de == 2'd0) ? s : d;
          for (int b = 0; b < beats; b++)
            push(de == 2'd0, de != 2'd0, 1'b1, m + 4 * b, 1'b0, 0);
        end else begin
          base = s;
          if (ind) begin
            push(1'b1, 1'b0, 1'b0, s, 1'b0, 0);
            base = memval(s);
          end
          for (int b = 0; b < beats; b++) push(1'b1, 1'b0, 1'b0, base + 4 * b, 1'b0, 0);
          for (int b = 0; b < beats; b++)
            push(1'b0, 1'b1, 1'b0, d + 4 * b, 1'b1, memval(base + 4 * b));
        end
      end
    end
    cur_tag = tag;
    rises = 0; strobes = 0;
    cfg_src_ep = se; cfg_dst_ep = de; cfg_dual = du; cfg_indirect = ind;
    cfg_burst = bu; cfg_size = sz; cfg_count = 16'(cnt);
    cfg_src_addr = sa; cfg_dst_addr = da;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_done = 1'b0; got_err = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (done || cfg_err) begin
        got_done = done; got_err = cfg_err;
        break;
      end
      @(negedge clk);
    end
    chk(got_done == exp_ok && got_err == !exp_ok, tag, "done/cfg_err outcome",
        {got_done, got_err}, {exp_ok, !exp_ok});
    chk(exp_q.size() == 0, tag, "events left in scoreboard", exp_q.size(), 0);
    if (exp_ok) chk(rises == (bu ? 1 : cnt), tag, "bus_req rise count", rises, bu ? 1 : cnt);
    else        chk(strobes == 0 && rises == 0, tag, "bus activity on refusal",
                    strobes + rises, 0);
    exp_q.delete();
  endtask

  task automatic gap();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset values
    chk({bus_req, bus_rd, bus_wr, dack, done, cfg_err} == 6'b0, "R12",
        "outputs in reset", {bus_req, bus_rd, bus_wr, dack, done, cfg_err}, 0);
    rst_n = 1'b1;
    gap();
    chk({bus_req, bus_rd, bus_wr, dack, done, cfg_err} == 6'b0, "R12",
        "outputs idle after reset", {bus_req, bus_rd, bus_wr, dack, done, cfg_err}, 0);

    // R4 R8: dual direct, cycle steal, 4-byte units
    run_job("R4", 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2, 3, 32'h0000_0010, 32'h0000_0080, 1'b1); gap();
    // R7 R8: byte units in burst, on-chip source
    run_job("R7", 2'd3, 2'd1, 1'b1, 1'b0, 1'b1, 2'd0, 4, 32'h0000_0021, 32'h0000_00A0, 1'b1); gap();
    run_job("R7", 2'd2, 2'd3, 1'b1, 1'b0, 1'b1, 2'd1, 3, 32'h0000_0040, 32'h0000_0090, 1'b1); gap();
    // R5: indirect dual
    run_job("R5", 2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 2'd2, 2, 32'h0000_0030, 32'h0000_00C0, 1'b1); gap();
    // R9 R5: 16-byte units, indirect, burst
    run_job("R9", 2'd1, 2'd2, 1'b1, 1'b1, 1'b1, 2'd3, 2, 32'h0000_0004, 32'h0000_0100, 1'b1); gap();
    // R6 R5: single, handshake device to memory, indirect flag set but ignored
    run_job("R6", 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 2'd2, 2, 32'h0000_0000, 32'h0000_0060, 1'b1); gap();
    // R6 R9: single, memory-mapped device source toward handshake device, 16 bytes
    run_job("R6", 2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 2'd3, 1, 32'h0000_0070, 32'h0000_0000, 1'b1); gap();

    // R1 R2 R3: refusals
    run_job("R1", 2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 2'd2, 2, 0, 32'h40, 1'b0); gap();
    run_job("R1", 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd2, 2, 0, 32'h40, 1'b0); gap();
    run_job("R1", 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2, 0, 0, 32'h40, 1'b0); gap();
    run_job("R2", 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 2'd2, 2, 0, 32'h40, 1'b0); gap();
    run_job("R3", 2'd3, 2'd1, 1'b1, 1'b0, 1'b1, 2'd3, 1, 0, 32'h40, 1'b0); gap();

    // R10: grant withheld mid-transfer
    blocked = 0;
    fork
      run_job("R10", 2'd1, 2'd2, 1'b1, 1'b0, 1'b1, 2'd3, 2, 32'h10, 32'h90, 1'b1);
      begin
        repeat (7) @(negedge clk);
        gnt_block = 1'b1;
        repeat (6) @(negedge clk);
        gnt_block = 1'b0;
      end
    join
    chk(blocked == 0, "R10", "strobes while grant withheld", blocked, 0);
    gap();

    // R11: start while busy is ignored
    errs = 0;
    fork
      run_job("R11", 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2, 4, 32'h20, 32'hB0, 1'b1);
      begin
        repeat (6) @(negedge clk);
        cfg_src_ep = 2'd0; cfg_dst_ep = 2'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    gap();
    chk(errs == 0, "R11", "cfg_err after start while busy", errs, 0);

    // R11: start in the cycle done is high
    run_job("R11", 2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 2'd2, 2, 32'h08, 32'hD0, 1'b1);
    run_job("R11", 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 2'd1, 2, 32'h00, 32'h44, 1'b1);
    gap();

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule